// File: doc/BRIEF.md
# Instruction Micro-op Cracker

This block turns one fetched instruction into a short, ordered list of micro-operations for the back end of a load/store processor. The instruction arrives either as one 32-bit word or as a 64-bit prefixed pair: a prefix word plus the suffix word that follows it. The block recognises a small integer subset: the canonical no-op and the prefixed no-op, add-immediate (plain and prefixed), register-register add, word loads and stores (plain, with base update, and prefixed), the conditional branch with an optional count-register decrement, and moves between general registers and the link, count, target and time-base registers.

Each instruction expands into zero to three micro-ops. A slot carries a kind, a destination index, two source indices, a 64-bit immediate, and two flags that redirect the destination or the first source to a single scratch register. Memory operations split into an address-generation step and an access step. A decrementing branch splits into the counter update and the branch. An update store whose data register is also its base register needs three steps. The address goes to the scratch register first, then the store uses it, and a final move writes the new base. Anything outside the subset is reported as illegal and produces no micro-ops.

The result is registered. It appears one clock after the input is taken, with a valid strobe that follows the input strobe.

Top module: `uop_cracker`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `out_valid`=0, `out_count`=0, `out_illegal`=0 and every slot all-zero (kind NONE).
- R2: `out_valid` equals `in_valid` of the previous clock. When `in_valid` was low, the count, the illegal flag and every slot field are zero, whatever the instruction inputs held.
- R3: The word 0x60000000 without prefix, and any prefix word whose primary opcode (bits 31:26) is 1 and whose type field (bits 25:24) is 2'b11, give count 0 and illegal 0.
- R4: Kind codes are NONE=0, ADDI=1, ADDR=2, AGEN=3, LOAD=4, STORE=5, MOVE=6, BRANCH=7. Register indices are 0–31 for general registers, LR=32, CTR=33, TAR=34, TB=35, TBU=36, and 63 for the null register (reads zero, writes discarded). Opcode 14 (target bits 25:21, base bits 20:16, displacement bits 15:0) gives one ADDI slot: dst=target, src_a=base, or 63 when base is 0. The immediate is the displacement sign-extended to 64 bits.
- R5: Opcode 31 with bits 10:0 equal to {10'd266, 1'b0} gives one ADDR slot: dst=bits 25:21, src_a=bits 20:16, src_b=bits 15:11, immediate 0. The same encoding with bit 0 set is illegal.
- R6: Opcode 32 (load) and opcode 36 (store) give two slots. Slot 0 is AGEN writing the scratch register (dst_tmp=1) from base, or 63 when base is 0, plus the sign-extended displacement. Slot 1 is LOAD to bits 25:21 or STORE of bits 25:21 (in src_b), with its address from the scratch register (src_tmp=1).
- R7: Opcode 33 (load with update) and opcode 37 (store with update) give AGEN with dst=src_a=base, then the access addressed by the base register. Opcode 33 with base 0 or base equal to target is illegal. Opcode 37 with base 0 is illegal.
- R8: Opcode 37 whose data register equals its nonzero base gives three slots. AGEN goes to scratch. STORE takes its address from scratch and its data from the register. MOVE copies scratch (src_tmp=1) into the register.
- R9: Opcode 16 with bit 23 clear gives two slots: ADDI dst=src_a=33 with immediate −1, then BRANCH. With bit 23 set it gives the BRANCH alone. The branch has src_a=33 when decrementing, else 63. Its dst is 32 when bit 0 is set, else 63. Its immediate is the sign-extended {bits 15:2, 2'b00}.
- R10: Opcode 31 with bits 10:1 equal to 467 (move to special), 339 (move from special) or 371 (time-base read) gives one MOVE slot. The special-register number is {bits 15:11, bits 20:16}; 8→32, 9→33, 815→34, 268→35 and 269→36. The move-to form accepts only 8, 9 and 815. The move-from form accepts all five. The time-base read accepts only 268 and 269. Any other number is illegal.
- R11: With `in_prefixed`=1, a prefix (opcode 1) of type 2'b10 whose suffix opcode is 14, 32 or 36 decodes like R4 or R6, with fields taken from the suffix. Its immediate is {prefix bits 17:0, suffix bits 15:0} sign-extended from 34 bits.
- R12: Every other case gives count 0 and illegal 1 with every slot zero. This includes an unlisted opcode, opcode 1 without `in_prefixed`, and `in_prefixed` with a first word whose opcode is not 1.
- R13: Slots fill from slot 0 in execution order: slot i has a non-NONE kind exactly when i < `out_count`, and unused slots are all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_prefixed | input | 1 | Instruction is a prefix/suffix pair |
| in_word0 | input | 32 | Instruction word, or prefix word when prefixed |
| in_word1 | input | 32 | Suffix word (used only when prefixed) |
| out_valid | output | 1 | Result of the previous cycle's instruction |
| out_count | output | 2 | Number of filled slots (0–3) |
| out_illegal | output | 1 | Instruction outside the decoded subset |
| slot_kind | output | 3x3 | Micro-op kind per slot |
| slot_dst | output | 3x6 | Destination register index per slot |
| slot_src_a | output | 3x6 | First source index per slot |
| slot_src_b | output | 3x6 | Second source index per slot |
| slot_imm | output | 3x64 | Immediate per slot |
| slot_dst_tmp | output | 3 | Destination is the scratch register |
| slot_src_tmp | output | 3 | First source is the scratch register |

## Verification
Every result is due exactly one rising edge after the instruction is presented. The bench drives each instruction on a falling edge and, in the same call, queues the expected count, illegal flag and three slots. A monitor pops the queue on the next falling edge whenever `out_valid` is high, so each comparison lands half a cycle after the edge that registered the result. Idle cycles are checked the same way one edge after `in_valid` drops, with a decodable word left on the inputs to show it has no effect.

// File: rtl/ucrk_pkg.sv
package ucrk_pkg;

    localparam int XLEN   = 64;
    localparam int REG_W  = 6;
    localparam int GPR_W  = 5;
    localparam int NSLOT  = 3;
    localparam int CNT_W  = $clog2(NSLOT + 1);
    localparam int WORD_W = 32;
    localparam int SPR_W  = 10;
    localparam int LONG_W = 34;

    // register index space
    localparam logic [REG_W-1:0] IDX_LR   = REG_W'(32);
    localparam logic [REG_W-1:0] IDX_CTR  = REG_W'(33);
    localparam logic [REG_W-1:0] IDX_TAR  = REG_W'(34);
    localparam logic [REG_W-1:0] IDX_TB   = REG_W'(35);
    localparam logic [REG_W-1:0] IDX_TBU  = REG_W'(36);
    localparam logic [REG_W-1:0] IDX_NULL = REG_W'(63);

    // primary opcodes
    localparam logic [5:0] OPC_PREFIX = 6'd1;
    localparam logic [5:0] OPC_ADDI   = 6'd14;
    localparam logic [5:0] OPC_BC     = 6'd16;
    localparam logic [5:0] OPC_ORI    = 6'd24;
    localparam logic [5:0] OPC_EXT    = 6'd31;
    localparam logic [5:0] OPC_LW     = 6'd32;
    localparam logic [5:0] OPC_LWU    = 6'd33;
    localparam logic [5:0] OPC_SW     = 6'd36;
    localparam logic [5:0] OPC_SWU    = 6'd37;

    localparam logic [WORD_W-1:0] NOP_WORD = 32'h6000_0000;

    // prefix type field
    localparam logic [1:0] PFX_LONGIMM = 2'b10;
    localparam logic [1:0] PFX_NOP     = 2'b11;

    // extended opcodes (bits 10:1)
    localparam logic [9:0] XO_ADD   = 10'd266;
    localparam logic [9:0] XO_MTSR  = 10'd467;
    localparam logic [9:0] XO_MFSR  = 10'd339;
    localparam logic [9:0] XO_RDTB  = 10'd371;

    // special register numbers
    localparam logic [SPR_W-1:0] SR_LR  = 10'd8;
    localparam logic [SPR_W-1:0] SR_CTR = 10'd9;
    localparam logic [SPR_W-1:0] SR_TAR = 10'd815;
    localparam logic [SPR_W-1:0] SR_TB  = 10'd268;
    localparam logic [SPR_W-1:0] SR_TBU = 10'd269;

    typedef enum logic [2:0] {
        UK_NONE   = 3'd0,
        UK_ADDI   = 3'd1,
        UK_ADDR   = 3'd2,
        UK_AGEN   = 3'd3,
        UK_LOAD   = 3'd4,
        UK_STORE  = 3'd5,
        UK_MOVE   = 3'd6,
        UK_BRANCH = 3'd7
    } uop_kind_e;

    typedef struct packed {
        uop_kind_e         kind;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src_a;
        logic [REG_W-1:0]  src_b;
        logic [XLEN-1:0]   imm;
        logic              dst_tmp;
        logic              src_tmp;
    } uop_t;

    typedef uop_t [NSLOT-1:0] uop_vec_t;

    typedef enum logic [3:0] {
        CL_NOP,
        CL_ADDI,
        CL_ADD,
        CL_LOAD,
        CL_STORE,
        CL_LOADU,
        CL_STOREU,
        CL_STOREU_ALIAS,
        CL_BC,
        CL_MTSR,
        CL_MFSR,
        CL_ILLEGAL
    } iclass_e;

    typedef struct packed {
        logic [GPR_W-1:0] rt;
        logic [GPR_W-1:0] ra;
        logic [GPR_W-1:0] rb;
        logic [XLEN-1:0]  imm;
        logic [REG_W-1:0] sr_idx;
        logic             link;
        logic             dec;
    } ifields_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sext34(input logic [LONG_W-1:0] v);
        return {{(XLEN-LONG_W){v[LONG_W-1]}}, v};
    endfunction

    function automatic logic [REG_W-1:0] gpr(input logic [GPR_W-1:0] r);
        return {{(REG_W-GPR_W){1'b0}}, r};
    endfunction

    function automatic logic [REG_W-1:0] base_idx(input logic [GPR_W-1:0] r);
        return (r == '0) ? IDX_NULL : gpr(r);
    endfunction

    function automatic uop_t mk_uop(
        input uop_kind_e        k,
        input logic [REG_W-1:0] d,
        input logic [REG_W-1:0] a,
        input logic [REG_W-1:0] b,
        input logic [XLEN-1:0]  im,
        input logic             dt,
        input logic             st
    );
        uop_t u;
        u.kind    = k;
        u.dst     = d;
        u.src_a   = a;
        u.src_b   = b;
        u.imm     = im;
        u.dst_tmp = dt;
        u.src_tmp = st;
        return u;
    endfunction

endpackage

// File: rtl/uc_sr_map.sv
module uc_sr_map
    import ucrk_pkg::*;
(
    input  logic [SPR_W-1:0] sr_num,
    output logic [REG_W-1:0] sr_idx,
    output logic             can_write,
    output logic             can_read,
    output logic             is_timebase
);

    always_comb begin
        sr_idx      = IDX_NULL;
        can_write   = 1'b0;
        can_read    = 1'b0;
        is_timebase = 1'b0;
        unique case (sr_num)
            SR_LR:  begin sr_idx = IDX_LR;  can_write = 1'b1; can_read = 1'b1; end
            SR_CTR: begin sr_idx = IDX_CTR; can_write = 1'b1; can_read = 1'b1; end
            SR_TAR: begin sr_idx = IDX_TAR; can_write = 1'b1; can_read = 1'b1; end
            SR_TB:  begin sr_idx = IDX_TB;  can_read = 1'b1; is_timebase = 1'b1; end
            SR_TBU: begin sr_idx = IDX_TBU; can_read = 1'b1; is_timebase = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/uc_classify.sv
module uc_classify
    import ucrk_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic              prefixed,
    output iclass_e           cls,
    output ifields_t          fld
);

    logic [5:0]       opc;
    logic [5:0]       sfx_opc;
    logic [9:0]       xo;
    logic [SPR_W-1:0] sr_num;
    logic [REG_W-1:0] sr_idx;
    logic             sr_wr;
    logic             sr_rd;
    logic             sr_tb;

    assign opc     = word0[31:26];
    assign sfx_opc = word1[31:26];
    assign xo      = word0[10:1];
    assign sr_num  = {word0[15:11], word0[20:16]};

    uc_sr_map u_sr_map (
        .sr_num      (sr_num),
        .sr_idx      (sr_idx),
        .can_write   (sr_wr),
        .can_read    (sr_rd),
        .is_timebase (sr_tb)
    );

    always_comb begin
        cls        = CL_ILLEGAL;
        fld.rt     = word0[25:21];
        fld.ra     = word0[20:16];
        fld.rb     = word0[15:11];
        fld.imm    = sext16(word0[15:0]);
        fld.sr_idx = sr_idx;
        fld.link   = word0[0];
        fld.dec    = ~word0[23];

        if (prefixed) begin
            if (opc == OPC_PREFIX) begin
                if (word0[25:24] == PFX_NOP) begin
                    cls = CL_NOP;
                end else if (word0[25:24] == PFX_LONGIMM) begin
                    fld.rt  = word1[25:21];
                    fld.ra  = word1[20:16];
                    fld.imm = sext34({word0[17:0], word1[15:0]});
                    unique case (sfx_opc)
                        OPC_ADDI: cls = CL_ADDI;
                        OPC_LW:   cls = CL_LOAD;
                        OPC_SW:   cls = CL_STORE;
                        default:  cls = CL_ILLEGAL;
                    endcase
                end
            end
        end else begin
            unique case (opc)
                OPC_ORI:  if (word0 == NOP_WORD) cls = CL_NOP;
                OPC_ADDI: cls = CL_ADDI;
                OPC_LW:   cls = CL_LOAD;
                OPC_SW:   cls = CL_STORE;
                OPC_LWU: begin
                    if (fld.ra != '0 && fld.ra != fld.rt) cls = CL_LOADU;
                end
                OPC_SWU: begin
                    if (fld.ra != '0)
                        cls = (fld.ra == fld.rt) ? CL_STOREU_ALIAS : CL_STOREU;
                end
                OPC_BC: begin
                    cls     = CL_BC;
                    fld.imm = sext16({word0[15:2], 2'b00});
                end
                OPC_EXT: begin
                    if (word0[10:0] == {XO_ADD, 1'b0}) begin
                        cls = CL_ADD;
                    end else if (word0[0] == 1'b0) begin
                        unique case (xo)
                            XO_MTSR: if (sr_wr) cls = CL_MTSR;
                            XO_MFSR: if (sr_rd) cls = CL_MFSR;
                            XO_RDTB: if (sr_tb) cls = CL_MFSR;
                            default: ;
                        endcase
                    end
                end
                default: cls = CL_ILLEGAL;
            endcase
        end
    end

endmodule

// File: rtl/uc_expand.sv
module uc_expand
    import ucrk_pkg::*;
(
    input  iclass_e          cls,
    input  ifields_t         fld,
    output logic [CNT_W-1:0] count,
    output logic             illegal,
    output uop_vec_t         uops
);

    localparam logic [XLEN-1:0] MINUS_ONE = '1;
    localparam logic [XLEN-1:0] ZERO_IMM  = '0;

    logic [REG_W-1:0] rt_i;
    logic [REG_W-1:0] ra_i;
    logic [REG_W-1:0] rb_i;
    logic [REG_W-1:0] base_i;

    assign rt_i   = gpr(fld.rt);
    assign ra_i   = gpr(fld.ra);
    assign rb_i   = gpr(fld.rb);
    assign base_i = base_idx(fld.ra);

    always_comb begin
        count   = '0;
        illegal = 1'b0;
        uops    = '0;
        unique case (cls)
            CL_NOP: count = '0;
            CL_ADDI: begin
                count   = CNT_W'(1);
                uops[0] = mk_uop(UK_ADDI, rt_i, base_i, '0, fld.imm, 1'b0, 1'b0);
            end
            CL_ADD: begin
                count   = CNT_W'(1);
                uops[0] = mk_uop(UK_ADDR, rt_i, ra_i, rb_i, ZERO_IMM, 1'b0, 1'b0);
            end
            CL_LOAD: begin
                count   = CNT_W'(2);
                uops[0] = mk_uop(UK_AGEN, '0, base_i, '0, fld.imm, 1'b1, 1'b0);
                uops[1] = mk_uop(UK_LOAD, rt_i, '0, '0, ZERO_IMM, 1'b0, 1'b1);
            end
            CL_STORE: begin
                count   = CNT_W'(2);
                uops[0] = mk_uop(UK_AGEN, '0, base_i, '0, fld.imm, 1'b1, 1'b0);
                uops[1] = mk_uop(UK_STORE, '0, '0, rt_i, ZERO_IMM, 1'b0, 1'b1);
            end
            CL_LOADU: begin
                count   = CNT_W'(2);
                uops[0] = mk_uop(UK_AGEN, ra_i, ra_i, '0, fld.imm, 1'b0, 1'b0);
                uops[1] = mk_uop(UK_LOAD, rt_i, ra_i, '0, ZERO_IMM, 1'b0, 1'b0);
            end
            CL_STOREU: begin
                count   = CNT_W'(2);
                uops[0] = mk_uop(UK_AGEN, ra_i, ra_i, '0, fld.imm, 1'b0, 1'b0);
                uops[1] = mk_uop(UK_STORE, '0, ra_i, rt_i, ZERO_IMM, 1'b0, 1'b0);
            end
            CL_STOREU_ALIAS: begin
                count   = CNT_W'(3);
                uops[0] = mk_uop(UK_AGEN, '0, ra_i, '0, fld.imm, 1'b1, 1'b0);
                uops[1] = mk_uop(UK_STORE, '0, '0, rt_i, ZERO_IMM, 1'b0, 1'b1);
                uops[2] = mk_uop(UK_MOVE, ra_i, '0, '0, ZERO_IMM, 1'b0, 1'b1);
            end
            CL_BC: begin
                if (fld.dec) begin
                    count   = CNT_W'(2);
                    uops[0] = mk_uop(UK_ADDI, IDX_CTR, IDX_CTR, '0, MINUS_ONE, 1'b0, 1'b0);
                    uops[1] = mk_uop(UK_BRANCH, fld.link ? IDX_LR : IDX_NULL, IDX_CTR,
                                     '0, fld.imm, 1'b0, 1'b0);
                end else begin
                    count   = CNT_W'(1);
                    uops[0] = mk_uop(UK_BRANCH, fld.link ? IDX_LR : IDX_NULL, IDX_NULL,
                                     '0, fld.imm, 1'b0, 1'b0);
                end
            end
            CL_MTSR: begin
                count   = CNT_W'(1);
                uops[0] = mk_uop(UK_MOVE, fld.sr_idx, rt_i, '0, ZERO_IMM, 1'b0, 1'b0);
            end
            CL_MFSR: begin
                count   = CNT_W'(1);
                uops[0] = mk_uop(UK_MOVE, rt_i, fld.sr_idx, '0, ZERO_IMM, 1'b0, 1'b0);
            end
            default: illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
    import ucrk_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic                            in_prefixed,
    input  logic [WORD_W-1:0]               in_word0,
    input  logic [WORD_W-1:0]               in_word1,
    output logic                            out_valid,
    output logic [CNT_W-1:0]                out_count,
    output logic                            out_illegal,
    output logic [NSLOT-1:0][2:0]           slot_kind,
    output logic [NSLOT-1:0][REG_W-1:0]     slot_dst,
    output logic [NSLOT-1:0][REG_W-1:0]     slot_src_a,
    output logic [NSLOT-1:0][REG_W-1:0]     slot_src_b,
    output logic [NSLOT-1:0][XLEN-1:0]      slot_imm,
    output logic [NSLOT-1:0]                slot_dst_tmp,
    output logic [NSLOT-1:0]                slot_src_tmp
);

    iclass_e          cls;
    ifields_t         fld;
    logic [CNT_W-1:0] dec_count;
    logic             dec_illegal;
    uop_vec_t         dec_uops;

    logic             valid_q;
    logic [CNT_W-1:0] count_q;
    logic             illegal_q;
    uop_vec_t         uops_q;

    uc_classify u_classify (
        .word0    (in_word0),
        .word1    (in_word1),
        .prefixed (in_prefixed),
        .cls      (cls),
        .fld      (fld)
    );

    uc_expand u_expand (
        .cls     (cls),
        .fld     (fld),
        .count   (dec_count),
        .illegal (dec_illegal),
        .uops    (dec_uops)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            count_q   <= '0;
            illegal_q <= 1'b0;
            uops_q    <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                count_q   <= dec_count;
                illegal_q <= dec_illegal;
                uops_q    <= dec_uops;
            end else begin
                count_q   <= '0;
                illegal_q <= 1'b0;
                uops_q    <= '0;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_count   = count_q;
    assign out_illegal = illegal_q;

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign slot_kind[i]    = uops_q[i].kind;
        assign slot_dst[i]     = uops_q[i].dst;
        assign slot_src_a[i]   = uops_q[i].src_a;
        assign slot_src_b[i]   = uops_q[i].src_b;
        assign slot_imm[i]     = uops_q[i].imm;
        assign slot_dst_tmp[i] = uops_q[i].dst_tmp;
        assign slot_src_tmp[i] = uops_q[i].src_tmp;

        // R13: slot occupancy matches the count, filled from slot 0
        a_r13_slot_order: assert property (@(posedge clk) disable iff (rst)
            (CNT_W'(i) < out_count) == (slot_kind[i] != 3'(UK_NONE)));
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_count == '0 && !out_illegal));

    a_r12_illegal_empty: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_count == '0 && slot_kind[0] == 3'(UK_NONE)));

    a_r6_access_after_agen: assert property (@(posedge clk) disable iff (rst)
        (slot_kind[1] == 3'(UK_LOAD) || slot_kind[1] == 3'(UK_STORE))
            |-> slot_kind[0] == 3'(UK_AGEN));

    a_r8_alias_sequence: assert property (@(posedge clk) disable iff (rst)
        (out_count == CNT_W'(3)) |-> (slot_dst_tmp[0] && slot_src_tmp[1]
            && slot_src_tmp[2] && slot_kind[2] == 3'(UK_MOVE)));

    a_r9_ctr_first: assert property (@(posedge clk) disable iff (rst)
        (slot_kind[1] == 3'(UK_BRANCH)) |-> (slot_dst[0] == IDX_CTR
            && slot_imm[0] == {XLEN{1'b1}}));

endmodule

// File: tb/tb_uop_cracker.sv
`timescale 1ns/1ps
module tb_uop_cracker;

    localparam int CLK_HALF = 10;
    localparam int WATCHDOG = 200000;

    localparam logic [2:0] K_NONE = 3'd0, K_ADDI = 3'd1, K_ADDR = 3'd2, K_AGEN = 3'd3,
                           K_LOAD = 3'd4, K_STORE = 3'd5, K_MOVE = 3'd6, K_BR = 3'd7;
    localparam logic [5:0] X_LR = 6'd32, X_CTR = 6'd33, X_TAR = 6'd34, X_TBU = 6'd36,
                           X_NULL = 6'd63;

    typedef struct packed {
        logic [2:0]  kind;
        logic [5:0]  dst;
        logic [5:0]  sa;
        logic [5:0]  sb;
        logic [63:0] imm;
        logic        dt;
        logic        st;
    } eslot_t;

    typedef struct packed {
        logic [1:0]       cnt;
        logic             ill;
        eslot_t [2:0]     s;
    } exp_t;

    logic                clk;
    logic                rst;
    logic                in_valid;
    logic                in_prefixed;
    logic [31:0]         in_word0;
    logic [31:0]         in_word1;
    logic                out_valid;
    logic [1:0]          out_count;
    logic                out_illegal;
    logic [2:0][2:0]     slot_kind;
    logic [2:0][5:0]     slot_dst;
    logic [2:0][5:0]     slot_src_a;
    logic [2:0][5:0]     slot_src_b;
    logic [2:0][63:0]    slot_imm;
    logic [2:0]          slot_dst_tmp;
    logic [2:0]          slot_src_tmp;

    uop_cracker dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_prefixed  (in_prefixed),
        .in_word0     (in_word0),
        .in_word1     (in_word1),
        .out_valid    (out_valid),
        .out_count    (out_count),
        .out_illegal  (out_illegal),
        .slot_kind    (slot_kind),
        .slot_dst     (slot_dst),
        .slot_src_a   (slot_src_a),
        .slot_src_b   (slot_src_b),
        .slot_imm     (slot_imm),
        .slot_dst_tmp (slot_dst_tmp),
        .slot_src_tmp (slot_src_tmp)
    );

    initial clk = 1'b0;
    always #(CLK_HALF) clk = ~clk;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    string tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic eslot_t mk(input logic [2:0] k, input logic [5:0] d,
                                  input logic [5:0] a, input logic [5:0] b,
                                  input logic [63:0] im, input logic dt, input logic st);
        eslot_t e;
        e.kind = k; e.dst = d; e.sa = a; e.sb = b; e.imm = im; e.dt = dt; e.st = st;
        return e;
    endfunction

    function automatic exp_t ex(input logic [1:0] c, input logic il,
                                input eslot_t s0, input eslot_t s1, input eslot_t s2);
        exp_t e;
        e.cnt = c; e.ill = il; e.s[0] = s0; e.s[1] = s1; e.s[2] = s2;
        return e;
    endfunction

    function automatic logic [31:0] dfm(input logic [5:0] op, input logic [4:0] t,
                                        input logic [4:0] a, input logic [15:0] d);
        return {op, t, a, d};
    endfunction

    function automatic logic [31:0] srf(input logic [4:0] t, input logic [9:0] sr,
                                        input logic [9:0] xo);
        return {6'd31, t, sr[4:0], sr[9:5], xo, 1'b0};
    endfunction

    task automatic send(input string tag, input logic pfx, input logic [31:0] w0,
                        input logic [31:0] w1, input exp_t e);
        @(negedge clk);
        in_valid    = 1'b1;
        in_prefixed = pfx;
        in_word0    = w0;
        in_word1    = w1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares one cycle after each accepted instruction
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 128'(out_count), 128'(0));
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_count == e.cnt, t, "count", 128'(out_count), 128'(e.cnt));
                check(out_illegal == e.ill, t, "illegal", 128'(out_illegal), 128'(e.ill));
                for (int i = 0; i < 3; i++) begin
                    eslot_t g;
                    g = mk(slot_kind[i], slot_dst[i], slot_src_a[i], slot_src_b[i],
                           slot_imm[i], slot_dst_tmp[i], slot_src_tmp[i]);
                    check(g == e.s[i], t, $sformatf("slot%0d", i), 128'(g), 128'(e.s[i]));
                end
            end
        end
    end

    task automatic check_quiet(input string req);
        check(out_valid == 1'b0, req, "out_valid", 128'(out_valid), 128'(0));
        check(out_count == 2'd0 && out_illegal == 1'b0, req, "count/illegal",
              128'({out_count, out_illegal}), 128'(0));
        check(slot_kind == '0 && slot_imm == '0 && slot_dst == '0 && slot_src_a == '0
              && slot_src_b == '0 && slot_dst_tmp == '0 && slot_src_tmp == '0,
              req, "slots", 128'(slot_kind), 128'(0));
    endtask

    initial begin
        #(2 * CLK_HALF * WATCHDOG);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        eslot_t z;
        z           = '0;
        rst         = 1'b1;
        in_valid    = 1'b1;
        in_prefixed = 1'b0;
        in_word0    = dfm(6'd14, 5'd1, 5'd2, 16'h0003);
        in_word1    = '0;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        in_valid = 1'b0;
        rst      = 1'b0;

        // R3 no-ops
        send("R3", 1'b0, 32'h6000_0000, 32'h0, ex(2'd0, 1'b0, z, z, z));
        send("R3", 1'b1, {6'd1, 2'b11, 24'd0}, 32'h1234_5678, ex(2'd0, 1'b0, z, z, z));
        // R4 add immediate
        send("R4", 1'b0, dfm(6'd14, 5'd3, 5'd4, 16'hFFFB),
             32'h0, ex(2'd1, 1'b0, mk(K_ADDI, 6'd3, 6'd4, 6'd0, -64'sd5, 0, 0), z, z));
        send("R4", 1'b0, dfm(6'd14, 5'd5, 5'd0, 16'd100),
             32'h0, ex(2'd1, 1'b0, mk(K_ADDI, 6'd5, X_NULL, 6'd0, 64'd100, 0, 0), z, z));
        // R5 register add
        send("R5", 1'b0, {6'd31, 5'd1, 5'd2, 5'd3, 10'd266, 1'b0},
             32'h0, ex(2'd1, 1'b0, mk(K_ADDR, 6'd1, 6'd2, 6'd3, 64'd0, 0, 0), z, z));
        send("R5", 1'b0, {6'd31, 5'd1, 5'd2, 5'd3, 10'd266, 1'b1},
             32'h0, ex(2'd0, 1'b1, z, z, z));
        // R6 plain load/store
        send("R6", 1'b0, dfm(6'd32, 5'd7, 5'd9, 16'd8), 32'h0,
             ex(2'd2, 1'b0, mk(K_AGEN, 6'd0, 6'd9, 6'd0, 64'd8, 1, 0),
                mk(K_LOAD, 6'd7, 6'd0, 6'd0, 64'd0, 0, 1), z));
        send("R6", 1'b0, dfm(6'd36, 5'd6, 5'd0, 16'hFFFC), 32'h0,
             ex(2'd2, 1'b0, mk(K_AGEN, 6'd0, X_NULL, 6'd0, -64'sd4, 1, 0),
                mk(K_STORE, 6'd0, 6'd0, 6'd6, 64'd0, 0, 1), z));
        // R7 update forms
        send("R7", 1'b0, dfm(6'd33, 5'd5, 5'd2, 16'd16), 32'h0,
             ex(2'd2, 1'b0, mk(K_AGEN, 6'd2, 6'd2, 6'd0, 64'd16, 0, 0),
                mk(K_LOAD, 6'd5, 6'd2, 6'd0, 64'd0, 0, 0), z));
        send("R7", 1'b0, dfm(6'd33, 5'd2, 5'd2, 16'd16), 32'h0, ex(2'd0, 1'b1, z, z, z));
        send("R7", 1'b0, dfm(6'd37, 5'd4, 5'd1, 16'hFFF8), 32'h0,
             ex(2'd2, 1'b0, mk(K_AGEN, 6'd1, 6'd1, 6'd0, -64'sd8, 0, 0),
                mk(K_STORE, 6'd0, 6'd1, 6'd4, 64'd0, 0, 0), z));
        send("R7", 1'b0, dfm(6'd37, 5'd3, 5'd0, 16'd4), 32'h0, ex(2'd0, 1'b1, z, z, z));
        // R8 aliased update store
        send("R8", 1'b0, dfm(6'd37, 5'd1, 5'd1, 16'hFFF8), 32'h0,
             ex(2'd3, 1'b0, mk(K_AGEN, 6'd0, 6'd1, 6'd0, -64'sd8, 1, 0),
                mk(K_STORE, 6'd0, 6'd0, 6'd1, 64'd0, 0, 1),
                mk(K_MOVE, 6'd1, 6'd0, 6'd0, 64'd0, 0, 1)));
        // R9 branches
        send("R9", 1'b0, {6'd16, 5'd16, 5'd0, 16'h0041}, 32'h0,
             ex(2'd2, 1'b0, mk(K_ADDI, X_CTR, X_CTR, 6'd0, {64{1'b1}}, 0, 0),
                mk(K_BR, X_LR, X_CTR, 6'd0, 64'h40, 0, 0), z));
        send("R9", 1'b0, {6'd16, 5'd20, 5'd0, 16'hFFF8}, 32'h0,
             ex(2'd1, 1'b0, mk(K_BR, X_NULL, X_NULL, 6'd0, -64'sd8, 0, 0), z, z));
        // R10 special-register moves
        send("R10", 1'b0, srf(5'd5, 10'd8, 10'd467), 32'h0,
             ex(2'd1, 1'b0, mk(K_MOVE, X_LR, 6'd5, 6'd0, 64'd0, 0, 0), z, z));
        send("R10", 1'b0, srf(5'd6, 10'd815, 10'd339), 32'h0,
             ex(2'd1, 1'b0, mk(K_MOVE, 6'd6, X_TAR, 6'd0, 64'd0, 0, 0), z, z));
        send("R10", 1'b0, srf(5'd7, 10'd269, 10'd371), 32'h0,
             ex(2'd1, 1'b0, mk(K_MOVE, 6'd7, X_TBU, 6'd0, 64'd0, 0, 0), z, z));
        send("R10", 1'b0, srf(5'd7, 10'd268, 10'd467), 32'h0, ex(2'd0, 1'b1, z, z, z));
        send("R10", 1'b0, srf(5'd7, 10'd8, 10'd371), 32'h0, ex(2'd0, 1'b1, z, z, z));
        // R11 prefixed forms
        send("R11", 1'b1, {6'd1, 2'b10, 6'd0, 18'h20000}, dfm(6'd14, 5'd3, 5'd4, 16'h0005),
             ex(2'd1, 1'b0, mk(K_ADDI, 6'd3, 6'd4, 6'd0, 64'hFFFF_FFFE_0000_0005, 0, 0), z, z));
        send("R11", 1'b1, {6'd1, 2'b10, 6'd0, 18'h00001}, dfm(6'd32, 5'd8, 5'd10, 16'h0010),
             ex(2'd2, 1'b0, mk(K_AGEN, 6'd0, 6'd10, 6'd0, 64'h1_0010, 1, 0),
                mk(K_LOAD, 6'd8, 6'd0, 6'd0, 64'd0, 0, 1), z));
        send("R11", 1'b1, {6'd1, 2'b10, 6'd0, 18'h0}, dfm(6'd36, 5'd9, 5'd0, 16'h0),
             ex(2'd2, 1'b0, mk(K_AGEN, 6'd0, X_NULL, 6'd0, 64'd0, 1, 0),
                mk(K_STORE, 6'd0, 6'd0, 6'd9, 64'd0, 0, 1), z));
        // R12 illegal cases
        send("R12", 1'b0, dfm(6'd2, 5'd1, 5'd1, 16'd1), 32'h0, ex(2'd0, 1'b1, z, z, z));
        send("R12", 1'b0, {6'd1, 2'b10, 24'd0}, 32'h0, ex(2'd0, 1'b1, z, z, z));
        send("R12", 1'b1, dfm(6'd14, 5'd1, 5'd1, 16'd1), 32'h0, ex(2'd0, 1'b1, z, z, z));
        send("R12", 1'b1, {6'd1, 2'b10, 24'd0}, dfm(6'd33, 5'd1, 5'd2, 16'd0),
             ex(2'd0, 1'b1, z, z, z));

        // R2: idle cycle with a decodable word on the inputs has no effect
        @(negedge clk);
        in_valid    = 1'b0;
        in_prefixed = 1'b0;
        in_word0    = dfm(6'd37, 5'd1, 5'd1, 16'h0004);
        @(negedge clk);
        check_quiet("R2");
        // R13: back-to-back after idle still fills from slot 0
        send("R13", 1'b0, dfm(6'd14, 5'd2, 5'd0, 16'd1), 32'h0,
             ex(2'd1, 1'b0, mk(K_ADDI, 6'd2, X_NULL, 6'd0, 64'd1, 0, 0), z, z));
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending results", 128'(exp_q.size()), 128'(0));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule